// File: doc/BRIEF.md
# Kernel/User Privilege Status Unit

This block is the privilege slice of the system-control coprocessor in a small RISC core. It keeps three pairs of mode and interrupt-enable bits: the current pair, the previous pair and the old pair. Taking an exception pushes the pairs one level deeper and drops the core into kernel mode with interrupts off. A return-from-exception instruction pops them back.

Every coprocessor-0 instruction is checked against the privilege that the core holds at that moment. The decoded strobes are read-from-coprocessor, write-to-coprocessor and return-from-exception. When user code issues one of them, the block raises a coprocessor-unusable trap and the instruction has no effect. A trapped read also has its register write-back killed in the same cycle. A write that switches the core from kernel to user mode still runs with kernel rights. The instruction right after it is already checked as user code.

Top module: `priv_status_unit`

## Requirements
- R1: After reset all six status bits are 0 (kernel mode, interrupts disabled at every level), `trap_o` is 0 and `trap_cause_o` is 0.
- R2: `status_o` bit 0 is the current enable, bit 1 the current mode, bits 2/3 the previous enable/mode, bits 4/5 the old enable/mode, and every higher bit reads 0. A mode bit of 1 means user. In kernel mode, `mtc0_i` loads `wdata_i[5:0]` into these bits at the next clock edge.
- R3: On `exc_i`, the next status is: old gets the previous pair, previous gets the current pair, and the current pair becomes 00 (kernel, disabled).
- R4: On `rfe_i` in kernel mode, the current pair gets the previous pair, the previous pair gets the old pair, and the old pair keeps its value.
- R5: When `exc_i` is high, it takes priority over `rfe_i` and `mtc0_i` in the same cycle. Only the push of R3 happens, and no trap is raised.
- R6: A `mfc0_i`, `mtc0_i` or `rfe_i` issued in user mode without `exc_i` leaves the status unchanged. In the next cycle it drives `trap_o` high for exactly one cycle, with `trap_cause_o` = 11 and `trap_cpnum_o` = 0. When `trap_o` is low, `trap_cause_o` is 0.
- R7: `wb_kill_o` is high in the same cycle as a `mfc0_i` issued in user mode, and low otherwise.
- R8: A `mtc0_i` issued in kernel mode that sets the mode bit does not trap. The next coprocessor-0 access is checked as user mode.
- R9: `user_mode_o` and `int_en_o` always equal status bits 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mfc0_i | input | 1 | Coprocessor-0 read issued this cycle |
| mtc0_i | input | 1 | Status write issued this cycle |
| rfe_i | input | 1 | Return-from-exception issued this cycle |
| exc_i | input | 1 | Exception taken this cycle |
| wdata_i | input | DATA_W | Status write value |
| status_o | output | DATA_W | Status image |
| user_mode_o | output | 1 | Current mode (1 = user) |
| int_en_o | output | 1 | Current interrupt enable |
| trap_o | output | 1 | Coprocessor-unusable trap request |
| trap_cause_o | output | 5 | Exception cause code |
| trap_cpnum_o | output | 2 | Offending coprocessor number |
| wb_kill_o | output | 1 | Kill the write-back of the current read |

## Verification
The sequence drives each of the three coprocessor strobes once in kernel mode and once in user mode. Comparing the two runs separates a privilege check that works from one that never fires or always fires.

Stacks with distinct values in every pair go through pushes and pops. This exposes any swapped pair or wrong shift direction.

A mode-switching write is followed directly by a read. This tells apart a check that samples the mode before the switch from one that samples it after.

Exception strobes coincide with a return and with a write. This shows whether the priority rule is kept or whether the two updates are merged.

// File: rtl/priv_pkg.sv
package priv_pkg;

    localparam int unsigned STAT_W   = 6;
    localparam int unsigned CAUSE_W  = 5;
    localparam int unsigned CPNUM_W  = 2;
    localparam logic [CAUSE_W-1:0] CAUSE_CPU  = 5'd11;
    localparam logic [CPNUM_W-1:0] CPNUM_SYS  = 2'd0;

    typedef struct packed {
        logic ku;   // 1 = user
        logic ie;
    } pair_t;

    typedef struct packed {
        pair_t old_p;
        pair_t prv_p;
        pair_t cur_p;
    } stack_t;

    localparam pair_t PAIR_KERNEL_OFF = '{ku: 1'b0, ie: 1'b0};

endpackage

// File: rtl/priv_check.sv
module priv_check
    import priv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mfc0_i,
    input  logic               mtc0_i,
    input  logic               rfe_i,
    input  logic               exc_i,
    input  logic               user_q_i,
    output logic               wr_ok_o,
    output logic               rfe_ok_o,
    output logic               trap_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [CPNUM_W-1:0] cpnum_o,
    output logic               kill_o
);

    typedef struct packed {
        logic               trap;
        logic [CAUSE_W-1:0] cause;
    } chk_t;

    chk_t chk_d, chk_q;
    logic access, denied;

    always_comb begin
        access   = mfc0_i | mtc0_i | rfe_i;
        denied   = access & user_q_i & ~exc_i;
        wr_ok_o  = mtc0_i & ~user_q_i & ~exc_i;
        rfe_ok_o = rfe_i  & ~user_q_i & ~exc_i;
        kill_o   = mfc0_i & user_q_i;
        chk_d.trap  = denied;
        chk_d.cause = denied ? CAUSE_CPU : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_q <= '0;
        else        chk_q <= chk_d;
    end

    assign trap_o  = chk_q.trap;
    assign cause_o = chk_q.cause;
    assign cpnum_o = CPNUM_SYS;

    a_r6_trap_source: assert property (@(posedge clk) disable iff (!rst_n)
        (mfc0_i || mtc0_i || rfe_i) && user_q_i && !exc_i |=> trap_o && cause_o == CAUSE_CPU);
    a_r6_cause_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_o |-> cause_o == '0);
    a_r7_kill_only_read: assert property (@(posedge clk) disable iff (!rst_n)
        kill_o |-> mfc0_i && user_q_i);
    a_r5_no_trap_on_exc: assert property (@(posedge clk) disable iff (!rst_n)
        exc_i |=> !trap_o);

endmodule

// File: rtl/priv_stack.sv
module priv_stack
    import priv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_i,
    input  logic              rfe_ok_i,
    input  logic              wr_ok_i,
    input  logic [STAT_W-1:0] wdata_i,
    output stack_t            stack_o
);

    stack_t stk_d, stk_q;

    always_comb begin
        stk_d = stk_q;
        if (exc_i) begin
            stk_d.old_p = stk_q.prv_p;
            stk_d.prv_p = stk_q.cur_p;
            stk_d.cur_p = PAIR_KERNEL_OFF;
        end else if (rfe_ok_i) begin
            stk_d.cur_p = stk_q.prv_p;
            stk_d.prv_p = stk_q.old_p;
        end else if (wr_ok_i) begin
            stk_d = stack_t'(wdata_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

    assign stack_o = stk_q;

    a_r3_exc_push: assert property (@(posedge clk) disable iff (!rst_n)
        exc_i |=> stack_o.cur_p == PAIR_KERNEL_OFF
                  && stack_o.prv_p == $past(stack_o.cur_p)
                  && stack_o.old_p == $past(stack_o.prv_p));
    a_r4_rfe_pop: assert property (@(posedge clk) disable iff (!rst_n)
        rfe_ok_i && !exc_i |=> stack_o.cur_p == $past(stack_o.prv_p)
                  && stack_o.prv_p == $past(stack_o.old_p)
                  && stack_o.old_p == $past(stack_o.old_p));
    a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_i && !rfe_ok_i && !wr_ok_i |=> $stable(stack_o));

endmodule

// File: rtl/priv_status_unit.sv
module priv_status_unit
    import priv_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mfc0_i,
    input  logic               mtc0_i,
    input  logic               rfe_i,
    input  logic               exc_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  status_o,
    output logic               user_mode_o,
    output logic               int_en_o,
    output logic               trap_o,
    output logic [CAUSE_W-1:0] trap_cause_o,
    output logic [CPNUM_W-1:0] trap_cpnum_o,
    output logic               wb_kill_o
);

    localparam int unsigned PAD_W = DATA_W - STAT_W;

    stack_t stack;
    logic   wr_ok, rfe_ok;

    priv_check u_check (
        .clk      (clk),
        .rst_n    (rst_n),
        .mfc0_i   (mfc0_i),
        .mtc0_i   (mtc0_i),
        .rfe_i    (rfe_i),
        .exc_i    (exc_i),
        .user_q_i (stack.cur_p.ku),
        .wr_ok_o  (wr_ok),
        .rfe_ok_o (rfe_ok),
        .trap_o   (trap_o),
        .cause_o  (trap_cause_o),
        .cpnum_o  (trap_cpnum_o),
        .kill_o   (wb_kill_o)
    );

    priv_stack u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .exc_i    (exc_i),
        .rfe_ok_i (rfe_ok),
        .wr_ok_i  (wr_ok),
        .wdata_i  (wdata_i[STAT_W-1:0]),
        .stack_o  (stack)
    );

    generate
        if (PAD_W > 0) begin : g_pad
            assign status_o = {{PAD_W{1'b0}}, stack};
        end else begin : g_nopad
            assign status_o = stack;
        end
    endgenerate

    assign user_mode_o = stack.cur_p.ku;
    assign int_en_o    = stack.cur_p.ie;

    a_r8_switch_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
        mtc0_i && !user_mode_o && !exc_i |=> !trap_o);
    a_r6_user_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        user_mode_o && !exc_i && !mtc0_i |=> $stable(status_o));
    a_r9_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        user_mode_o == status_o[1] && int_en_o == status_o[0]);

endmodule

// File: tb/priv_status_unit_bench.sv
`timescale 1ns/1ps
module priv_status_unit_bench;

    localparam int DATA_W = 32;
    localparam int NVEC   = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mfc0_i = 0, mtc0_i = 0, rfe_i = 0, exc_i = 0;
    logic [DATA_W-1:0] wdata_i = '0;
    logic [DATA_W-1:0] status_o;
    logic              user_mode_o, int_en_o, trap_o, wb_kill_o;
    logic [4:0]        trap_cause_o;
    logic [1:0]        trap_cpnum_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    priv_status_unit #(.DATA_W(DATA_W)) u_priv_status_unit (
        .clk(clk), .rst_n(rst_n), .mfc0_i(mfc0_i), .mtc0_i(mtc0_i),
        .rfe_i(rfe_i), .exc_i(exc_i), .wdata_i(wdata_i), .status_o(status_o),
        .user_mode_o(user_mode_o), .int_en_o(int_en_o), .trap_o(trap_o),
        .trap_cause_o(trap_cause_o), .trap_cpnum_o(trap_cpnum_o),
        .wb_kill_o(wb_kill_o)
    );

    // {exc, rfe, mtc0, mfc0} wdata exp_status exp_trap(next cycle) exp_kill
    localparam logic [17:0] VEC [NVEC] = '{
        {4'b0010, 6'h01, 6'h01, 1'b0, 1'b0}, // R2 kernel write, IE on
        {4'b0001, 6'h00, 6'h01, 1'b0, 1'b0}, // R7 kernel read, no kill
        {4'b1000, 6'h00, 6'h04, 1'b0, 1'b0}, // R3 push
        {4'b0010, 6'h26, 6'h26, 1'b0, 1'b0}, // R8 switch to user, no trap
        {4'b0001, 6'h00, 6'h26, 1'b1, 1'b1}, // R8 next read checked as user
        {4'b0010, 6'h00, 6'h26, 1'b1, 1'b0}, // R6 user write ignored
        {4'b0100, 6'h00, 6'h26, 1'b1, 1'b0}, // R6 user return ignored
        {4'b1000, 6'h00, 6'h18, 1'b0, 1'b0}, // R3 push distinct pairs
        {4'b0001, 6'h00, 6'h18, 1'b0, 1'b0}, // R7 kernel read
        {4'b0100, 6'h00, 6'h16, 1'b0, 1'b0}, // R4 pop
        {4'b1100, 6'h00, 6'h18, 1'b0, 1'b0}, // R5 exc beats return in user
        {4'b1010, 6'h3F, 6'h20, 1'b0, 1'b0}, // R5 exc beats write
        {4'b0100, 6'h00, 6'h28, 1'b0, 1'b0}, // R4 pop, old kept
        {4'b0100, 6'h00, 6'h2A, 1'b0, 1'b0}, // R4 pop into user
        {4'b0010, 6'h3F, 6'h2A, 1'b1, 1'b0}, // R6 user write ignored
        {4'b0000, 6'h00, 6'h2A, 1'b0, 1'b0}  // R6 trap lasts one cycle
    };

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp_v);
        end
    endtask

    task automatic check_reset_state();
        check(status_o == '0, "R1 status", int'(status_o), 0);
        check(trap_o == 1'b0, "R1 trap", int'(trap_o), 0);
        check(trap_cause_o == 5'd0, "R1 cause", int'(trap_cause_o), 0);
        check(user_mode_o == 1'b0 && int_en_o == 1'b0, "R1 mode/ie",
              int'({user_mode_o, int_en_o}), 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 check_reset_state();
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            {exc_i, rfe_i, mtc0_i, mfc0_i} = VEC[i][17:14];
            wdata_i = {{(DATA_W-6){1'b1}}, VEC[i][13:8]};
            #1;
            check(wb_kill_o == VEC[i][0], "R7 kill", int'(wb_kill_o), int'(VEC[i][0]));
            @(posedge clk);
            #1;
            check(status_o == {26'd0, VEC[i][7:2]}, "R2/R3/R4/R5 status",
                  int'(status_o), int'(VEC[i][7:2]));
            check(trap_o == VEC[i][1], "R6/R8 trap", int'(trap_o), int'(VEC[i][1]));
            check(trap_cause_o == (VEC[i][1] ? 5'd11 : 5'd0), "R6 cause",
                  int'(trap_cause_o), VEC[i][1] ? 11 : 0);
            check(trap_cpnum_o == 2'd0, "R6 cpnum", int'(trap_cpnum_o), 0);
            check(user_mode_o == VEC[i][3] && int_en_o == VEC[i][2], "R9 mirror",
                  int'({user_mode_o, int_en_o}), int'(VEC[i][3:2]));
        end

        // R6: a trap following an idle cycle is gone
        @(negedge clk);
        {exc_i, rfe_i, mtc0_i, mfc0_i} = 4'b0000;
        @(posedge clk); #1;
        check(trap_o == 1'b0, "R6 single pulse", int'(trap_o), 0);

        // R7: user read during exception still kills write-back, no trap
        @(negedge clk);
        {exc_i, mfc0_i} = 2'b11;
        #1 check(wb_kill_o == 1'b1, "R7 kill with exc", int'(wb_kill_o), 1);
        @(posedge clk); #1;
        check(trap_o == 1'b0, "R5 no trap with exc", int'(trap_o), 0);
        check(status_o == 32'h28, "R3 push from user", int'(status_o), 'h28);
        @(negedge clk);
        {exc_i, mfc0_i} = 2'b00;

        // R1: reset in the middle of a run
        @(negedge clk) rst_n = 1'b0;
        #1 check_reset_state();
        @(negedge clk) rst_n = 1'b1;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule